// File: doc/BRIEF.md
# Network Controller Interrupt Moderator

This block sits between the receive and transmit engines of a network controller and the CPU interrupt line. Interrupt causes arrive as single-cycle pulses and set bits in a pending-cause register. The host sees only the bits it enables in a mask register. A throttle timer enforces a minimum spacing between successive assertions of the line. A post flagged as immediate skips that spacing.

The block also runs four delay timers, a per-packet delay and an absolute delay for each direction. When a timer expires, the block pulses a descriptor writeback request for its direction and posts that direction's cause in the same clock edge. A per-packet timer restarts each time it is armed. An absolute timer keeps counting from its first arm. All timers count in ticks of 1024 ns, and a local prescaler derives the tick from the core clock. The host reaches every register through a small read/write port. Reading the cause register returns the pending bits and clears them.

Top module: `nic_irq_moderator`

## Requirements
- R1: After reset the interrupt line and both writeback request bits are low, and every register (cause, mask, throttle reload, four delay reloads) reads zero. The register addresses are 0 cause, 1 mask, 2 throttle reload, 3 receive per-packet reload, 4 receive absolute reload, 5 transmit per-packet reload, 6 transmit absolute reload.
- R2: A pulse on cause bit k sets bit k of the pending cause register. A read of address 0 returns the pending bits in data bits 7:0 and clears them at that clock edge. A post arriving at the same edge survives. If no unmasked cause remains after the read, the line is low one edge later.
- R3: The line is high only while some pending cause has its mask bit set. A mask write re-evaluates this at the write edge, so the line rises or falls with that edge.
- R4: Each rising edge of the line loads the throttle counter from the throttle reload. The counter counts down once per tick, and a tick is TICK_CYCLES clocks (1024 ns). While the counter is non-zero, a non-immediate cause cannot raise the line.
- R5: A post made with cause_now_i high raises the line at the next edge, even while the throttle counter is non-zero, provided the posted cause is unmasked.
- R6: A pulse on irq_clear_i drops the line at the next edge.
- R7: The receive per-packet timer, armed by rx_arm_i with reload N, expires after N ticks. At that edge it pulses wb_req_o bit 1 and sets cause bit 7. Re-arming while it runs restarts the count.
- R8: The receive absolute timer, armed by rx_arm_i with reload N, expires N ticks after the arm that started it. Later arms while it runs do not restart it. Expiry has the same effect as in R7.
- R9: Either transmit timer (per-packet at address 5, restarting; absolute at address 6, not restarting), armed by tx_arm_i, pulses wb_req_o bit 0 on expiry and sets cause bit 0.
- R10: A timer whose reload is zero never starts. Arming it produces no writeback request and no cause.
- R11: When either timer of a direction expires, the other timer of that direction stops, so one writeback covers both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears cause on address 0) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |
| cause_set_i | input | 8 | Cause pulses, one bit per source |
| cause_now_i | input | 1 | Marks this cycle's posts as immediate |
| rx_arm_i | input | 1 | Arms both receive delay timers |
| tx_arm_i | input | 1 | Arms both transmit delay timers |
| irq_clear_i | input | 1 | Deasserts the interrupt line |
| wb_req_o | output | 2 | Writeback request pulse: bit 1 receive, bit 0 transmit |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
Cause posts, mask writes, clears and cause reads all act at the edge that samples them, so the bench checks the line one edge later. A timer reloaded with N ticks pulses its writeback request between (N-1)*TICK_CYCLES+1 and N*TICK_CYCLES edges after the arming edge, because the free-running prescaler phase is unknown. The bench counts edges and checks that window for each timer and for N from 1 to 4. A throttled raise counted from the previous rise has to fall between (R-1)*TICK_CYCLES+2 and R*TICK_CYCLES+1 edges. The bench checks that window for several throttle reloads R. All outputs are sampled 1 ns after the edge.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  localparam int unsigned CAUSE_W   = 8;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned N_TIMERS  = 4;
  localparam int unsigned CAUSE_TXWB  = 0;
  localparam int unsigned CAUSE_RXTMR = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CAUSE    = 3'd0,
    A_MASK     = 3'd1,
    A_THROTTLE = 3'd2,
    A_RX_PKT   = 3'd3,
    A_RX_ABS   = 3'd4,
    A_TX_PKT   = 3'd5,
    A_TX_ABS   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int unsigned TICK_CYCLES = 205
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(TICK_CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  if (TICK_CYCLES > 1) begin : g_chk
    a_r4_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter bit          RESTART = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             arm_i,
  input  logic             stop_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             load;

  assign load     = arm_i && (reload_i != '0) && (RESTART || !run_q);
  assign expire_o = run_q && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload_i;
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r10_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && arm_i && reload_i == '0) |=> !run_q);

  if (!RESTART) begin : g_abs
    a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && arm_i && !tick_i && !stop_i) |=> (run_q && $stable(cnt_q)));
  end
endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 205  // 1024 ns at 200 MHz, rounded
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [CAUSE_W-1:0] cause_set_i,
  input  logic              cause_now_i,
  input  logic              rx_arm_i,
  input  logic              tx_arm_i,
  input  logic              irq_clear_i,
  output logic [1:0]        wb_req_o,
  output logic              irq_o
);
  logic               tick;
  logic [CAUSE_W-1:0] cause_q, mask_q, cause_n, mask_n, post;
  logic [DATA_W-1:0]  thr_reload_q, thr_cnt_q;
  logic [DATA_W-1:0]  dly_reload_q [N_TIMERS];
  logic [N_TIMERS-1:0] exp;
  logic               rx_exp, tx_exp, now_q, now_n, irq_n, rd_cause;

  irq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign rx_exp = exp[0] | exp[1];
  assign tx_exp = exp[2] | exp[3];

  // timers 0/1 receive, 2/3 transmit; even index restarts on arm
  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_reload_q[i] <= '0;
      else if (reg_we_i && reg_addr_i == ADDR_W'(A_RX_PKT + i))
        dly_reload_q[i] <= reg_wdata_i;
    end
    irq_delay_timer #(.CNT_W(DATA_W), .RESTART(i % 2 == 0)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .reload_i(dly_reload_q[i]),
      .arm_i   ((i < 2) ? rx_arm_i : tx_arm_i),
      .stop_i  ((i < 2) ? rx_exp : tx_exp),
      .expire_o(exp[i])
    );
  end

  always_comb begin
    post = cause_set_i;
    post[CAUSE_TXWB]  = post[CAUSE_TXWB]  | tx_exp;
    post[CAUSE_RXTMR] = post[CAUSE_RXTMR] | rx_exp;
  end

  assign rd_cause = reg_re_i && (reg_addr_i == A_CAUSE);
  assign cause_n  = (rd_cause ? '0 : cause_q) | post;
  assign mask_n   = (reg_we_i && reg_addr_i == A_MASK) ? reg_wdata_i[CAUSE_W-1:0] : mask_q;
  assign now_n    = now_q | (cause_now_i && (cause_set_i != '0));

  always_comb begin
    if (irq_clear_i || (cause_n & mask_n) == '0) irq_n = 1'b0;
    else if (irq_o)                               irq_n = 1'b1;
    else                                          irq_n = (thr_cnt_q == '0) || now_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q      <= '0;
      mask_q       <= '0;
      thr_reload_q <= '0;
      thr_cnt_q    <= '0;
      now_q        <= 1'b0;
      irq_o        <= 1'b0;
      wb_req_o     <= '0;
    end else begin
      cause_q  <= cause_n;
      mask_q   <= mask_n;
      now_q    <= now_n && !irq_n;
      irq_o    <= irq_n;
      wb_req_o <= {rx_exp, tx_exp};
      if (reg_we_i && reg_addr_i == A_THROTTLE) thr_reload_q <= reg_wdata_i;
      if (irq_n && !irq_o)                  thr_cnt_q <= thr_reload_q;
      else if (tick && thr_cnt_q != '0)     thr_cnt_q <= thr_cnt_q - 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CAUSE:    reg_rdata_o = DATA_W'(cause_q);
      A_MASK:     reg_rdata_o = DATA_W'(mask_q);
      A_THROTTLE: reg_rdata_o = thr_reload_q;
      A_RX_PKT:   reg_rdata_o = dly_reload_q[0];
      A_RX_ABS:   reg_rdata_o = dly_reload_q[1];
      A_TX_PKT:   reg_rdata_o = dly_reload_q[2];
      A_TX_ABS:   reg_rdata_o = dly_reload_q[3];
      default:    reg_rdata_o = '0;
    endcase
  end

  a_r3_line_needs_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((cause_q & mask_q) != '0));
  a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(irq_clear_i) |-> !irq_o);
  a_r4_throttle_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (thr_cnt_q == $past(thr_reload_q)));
  a_r4_no_early_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && !$past(cause_now_i) && !$past(now_q)) |-> ($past(thr_cnt_q) == '0));
  a_r7_rx_wb_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o[1] |-> cause_q[CAUSE_RXTMR]);
  a_r9_tx_wb_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o[0] |-> cause_q[CAUSE_TXWB]);
  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_cause) && $past(post) == '0) |-> (cause_q == '0));
endmodule

// File: tb/nic_irq_moderator_bench.sv
`timescale 1ns/1ps
module nic_irq_moderator_bench;
  localparam int T = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 0, reg_re_i = 0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0, reg_rdata_o;
  logic [7:0]  cause_set_i = '0;
  logic        cause_now_i = 0, rx_arm_i = 0, tx_arm_i = 0, irq_clear_i = 0;
  logic [1:0]  wb_req_o;
  logic        irq_o;
  int          total = 0, fails = 0;

  nic_irq_moderator #(.TICK_CYCLES(T)) u_nic_irq_moderator (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic cyc(); @(posedge clk_i); #1; endtask

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic chk_rng(input string r, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", r, act, lo, hi);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we_i = 1; reg_addr_i = 3'(a); reg_wdata_i = 16'(d);
    cyc();
    reg_we_i = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_re_i = 1; reg_addr_i = 3'(a);
    #1 d = int'(reg_rdata_o);
    cyc();
    reg_re_i = 0;
  endtask

  task automatic post(input int bits, input bit now);
    cause_set_i = 8'(bits); cause_now_i = now;
    cyc();
    cause_set_i = '0; cause_now_i = 0;
  endtask

  // arm a direction and count edges to the first writeback pulse
  task automatic arm_measure(input bit rx, input int limit, output int edges, output int wb);
    if (rx) rx_arm_i = 1; else tx_arm_i = 1;
    cyc();
    rx_arm_i = 0; tx_arm_i = 0;
    edges = -1; wb = 0;
    for (int k = 1; k <= limit; k++) begin
      cyc();
      if (wb_req_o != 0) begin edges = k; wb = int'(wb_req_o); break; end
    end
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int d, e, w, e2;
    #12 rst_ni = 1;
    cyc();
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 wb", wb_req_o, 0);
    for (int a = 0; a < 7; a++) begin rd(a, d); chk("R1 reg", d, 0); end

    // R1 register readback
    for (int a = 1; a < 7; a++) begin wr(a, 16'h0A00 + a); rd(a, d); chk("R1 rw", d, (a == 1) ? 8'h00 + a : 16'h0A00 + a); end
    for (int a = 1; a < 7; a++) wr(a, 0);

    // R7 R8 R9 timer sweep: one timer loaded at a time
    for (int i = 0; i < 4; i++) begin
      for (int n = 1; n <= 4; n++) begin
        string tg;
        tg = (i == 0) ? "R7" : (i == 1) ? "R8" : "R9";
        wr(3 + i, n);
        arm_measure(i < 2, 6 * T, e, w);
        chk_rng({tg, " expiry edge"}, e, (n - 1) * T + 1, n * T);
        chk({tg, " wb bit"}, w, (i < 2) ? 2 : 1);
        rd(0, d);
        chk({tg, " cause bit"}, d, (i < 2) ? 8'h80 : 8'h01);
        wr(3 + i, 0);
      end
    end

    // R7 restart on rearm
    wr(3, 3);
    rx_arm_i = 1; cyc(); rx_arm_i = 0;
    for (int k = 0; k < 2 * T; k++) cyc();
    chk("R7 no early wb", wb_req_o, 0);
    arm_measure(1, 6 * T, e, w);
    chk_rng("R7 restart edge", e, 2 * T + 1, 3 * T);
    rd(0, d); wr(3, 0);

    // R8 absolute ignores rearm; R9 transmit absolute likewise
    for (int dir = 0; dir < 2; dir++) begin
      wr(dir ? 4 : 6, 3);
      if (dir) rx_arm_i = 1; else tx_arm_i = 1;
      cyc(); rx_arm_i = 0; tx_arm_i = 0;
      for (int k = 0; k < 2 * T; k++) cyc();
      arm_measure(dir == 1, 6 * T, e, w);
      chk_rng(dir ? "R8 abs total" : "R9 abs total", e + 2 * T + 1, 2 * T + 1, 3 * T);
      rd(0, d); wr(dir ? 4 : 6, 0);
    end

    // R10 zero reload disables
    rx_arm_i = 1; tx_arm_i = 1; cyc(); rx_arm_i = 0; tx_arm_i = 0;
    w = 0;
    for (int k = 0; k < 6 * T; k++) begin cyc(); w |= int'(wb_req_o); end
    chk("R10 no wb", w, 0);
    rd(0, d); chk("R10 no cause", d, 0);

    // R11 sibling stopped by expiry
    for (int dir = 0; dir < 2; dir++) begin
      wr(dir ? 3 : 5, 2); wr(dir ? 4 : 6, 4);
      arm_measure(dir == 1, 6 * T, e, w);
      chk_rng("R11 first expiry", e, T + 1, 2 * T);
      w = 0;
      for (int k = 0; k < 5 * T; k++) begin cyc(); w |= int'(wb_req_o); end
      chk("R11 sibling silent", w, 0);
      rd(0, d); wr(dir ? 3 : 5, 0); wr(dir ? 4 : 6, 0);
    end

    // R3 mask gating and re-evaluation on write
    post(8'h10, 0);
    chk("R3 masked low", irq_o, 0);
    wr(1, 8'h10); chk("R3 unmask raises", irq_o, 1);
    wr(1, 8'h00); chk("R3 mask drops", irq_o, 0);
    rd(0, d);     chk("R2 pending kept", d, 8'h10);
    rd(0, d);     chk("R2 cleared", d, 0);

    // R2 read clears and drops line
    wr(1, 8'hFF);
    post(8'h24, 0); chk("R2 raise", irq_o, 1);
    rd(0, d); chk("R2 read value", d, 8'h24);
    chk("R2 read drops", irq_o, 0);
    // R2 post at read edge survives
    post(8'h02, 0);
    cause_set_i = 8'h08; reg_re_i = 1; reg_addr_i = 3'd0; #1 d = int'(reg_rdata_o);
    cyc(); cause_set_i = 0; reg_re_i = 0;
    chk("R2 read value 2", d, 8'h02);
    chk("R2 post survives line", irq_o, 1);
    rd(0, d); chk("R2 post survives", d, 8'h08);

    // R6 clear
    post(8'h01, 0); chk("R6 raise", irq_o, 1);
    irq_clear_i = 1; cyc(); irq_clear_i = 0;
    chk("R6 clear drops", irq_o, 0);
    rd(0, d);

    // R4 throttle sweep
    for (int r = 2; r <= 4; r++) begin
      wr(2, r);
      post(8'h02, 0);
      chk("R4 first raise", irq_o, 1);
      irq_clear_i = 1; cyc(); irq_clear_i = 0;
      rd(0, d);
      post(8'h04, 0);
      chk("R4 held", irq_o, 0);
      e2 = -1;
      for (int k = 4; k <= r * T + 4; k++) begin
        cyc();
        if (irq_o && e2 < 0) begin e2 = k; break; end
      end
      chk_rng("R4 spaced raise", e2, (r - 1) * T + 2, r * T + 1);
      rd(0, d);
      for (int k = 0; k < (r + 1) * T; k++) cyc();
    end

    // R5 immediate bypass
    wr(2, 8);
    post(8'h02, 0); chk("R5 first", irq_o, 1);
    irq_clear_i = 1; cyc(); irq_clear_i = 0;
    rd(0, d);
    post(8'h08, 1);
    chk("R5 immediate raise", irq_o, 1);
    rd(0, d); chk("R5 cause", d, 8'h08);
    wr(1, 8'h00);
    post(8'h40, 1);
    chk("R5 masked immediate stays low", irq_o, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule